// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block sits between a clock divider and the clock output pins. It receives divided clock waveforms as levels that are synchronous to a fast system clock, and it forwards them as registered output clocks. There are three output groups. Ordinary PCI-type outputs halt in the low state when the PCI stop input is pulled low. Free-running PCI-type outputs ignore that stop input. Differential CPU-type pairs halt on the CPU stop input, but only where a mask parameter marks the pair as stoppable. A stopped pair rests with its true leg low and its complement leg high.

Both stop inputs are asynchronous. Each one passes through a synchroniser of configurable depth. The PCI stop is then captured on one rising edge of the PCI source. The CPU stop is captured across two rising edges of the CPU source. Each output has a gate, and the gate may only change while its source is low. Because of this, every pulse that leaves the block is a complete high phase. Stopping, restarting, disabling and enabling therefore never produce a shortened pulse.

Each output also has its own enable bit, where 1 means enabled. A disabled output is held low no matter what the stop inputs do. A disabled pair drives both legs low, which keeps it distinguishable from a pair that is merely stopped.

Top module: `ckstop_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every ordinary, free-running and true output is 0 and every complement output is 1. All gates reset to open.
- R2: Every free-running output reproduces `pci_src` one `clk` cycle later, whatever `pci_stop_n` does. An enabled ordinary output that is not stopped does the same.
- R3: While `pci_stop_n` is held low, every ordinary PCI output settles to 0 and stays at 0.
- R4: Every high pulse on any gated output lasts exactly one high phase of its source, and an output only falls after its source is low. This holds in every case: stop, restart, disable and enable.
- R5: `pci_stop_n` passes through `SYNC_STAGES` flops and is then taken on the next `pci_src` rising edge. With the default depth, counting from the first `clk` edge after it falls, 1 or 2 further pulses appear on ordinary outputs before they stay low.
- R6: `cpu_stop_n` passes through `SYNC_STAGES` flops and then through two stages clocked by `cpu_src` rising edges. With the defaults, a stoppable pair shows 2 or 3 further true pulses before it stops.
- R7: A stopped, enabled, stoppable pair rests with true = 0 and complement = 1.
- R8: A pair whose bit i in `CPU_STOP_MASK` is 0 keeps toggling while `cpu_stop_n` is low (defaults: pair 0 stoppable, pair 1 not).
- R9: After a stop input returns high, output resumes with a full first high phase. The restart passes through the same synchroniser and the same capture stage as the stop. For ordinary PCI outputs with the default depth and a source period of 8 cycles, the first rise appears 10 to 19 `clk` cycles after the release.
- R10: Enable bit i (in `pci_en`, `free_en` or `cpu_en`) drives output i, and 1 means enabled. A disabled output stays 0 whatever the stop inputs do, and a disabled pair drives both legs low. Enable changes are applied only while the source is low, and setting the bit again brings the clock back.
- R11: For an enabled pair, the complement output is the inverse of the true output on every cycle. The two legs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sources are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| pci_src | input | 1 | Divided PCI-type source waveform |
| cpu_src | input | 1 | Divided CPU-type source waveform |
| pci_stop_n | input | 1 | Asynchronous active-low stop for ordinary PCI outputs |
| cpu_stop_n | input | 1 | Asynchronous active-low stop for stoppable CPU pairs |
| pci_en | input | N_PCI | Per-output enable of ordinary PCI outputs, 1 = enabled |
| free_en | input | N_FREE | Per-output enable of free-running outputs, 1 = enabled |
| cpu_en | input | N_CPU | Per-pair enable of CPU pairs, 1 = enabled |
| pci_clk_o | output | N_PCI | Gated ordinary PCI clocks |
| free_clk_o | output | N_FREE | Free-running PCI clocks |
| cpu_t_o | output | N_CPU | True legs of CPU pairs |
| cpu_c_o | output | N_CPU | Complement legs of CPU pairs |

## Verification
The hardest case to reach is a stop, release or enable change that lands in the middle of a source phase, one cycle before a gate would have updated. Only such a case can expose a shortened pulse or an extra pulse. To reach it, the bench aligns each stop assertion, stop release and enable toggle to every phase offset of the source period in turn. A monitor measures the length of every high pulse on every output. The bench counts the pulses that still emerge after each assertion and compares that count with the window set by the synchroniser and the capture edges.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;

  typedef struct packed {
    logic run;
    logic en;
  } gate_t;

  localparam gate_t GATE_OPEN = '{run: 1'b1, en: 1'b1};

  function automatic logic gate_passes(gate_t g);
    return g.run & g.en;
  endfunction

endpackage

// File: rtl/ckstop_sync.sv
module ckstop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ckstop_edge_cap.sv
module ckstop_edge_cap #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic din,
  output logic q
);
  logic             src_d;
  logic [DEPTH-1:0] sh;
  logic             rise;

  assign rise = src & ~src_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_d <= 1'b0;
      sh    <= {DEPTH{1'b1}};
    end else begin
      src_d <= src;
      if (rise) begin
        sh[0] <= din;
        for (int i = 1; i < DEPTH; i++) sh[i] <= sh[i-1];
      end
    end
  end

  assign q = sh[DEPTH-1];

  // R5/R6: the captured stop level only moves on a source rising edge
  p_hold_between_rises_r6: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(q));
endmodule

// File: rtl/ckstop_gate.sv
module ckstop_gate
  import ckstop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic run_req,
  input  logic en_req,
  output logic clk_o
);
  gate_t g;

  always_ff @(posedge clk) begin
    if (rst) begin
      g     <= GATE_OPEN;
      clk_o <= 1'b0;
    end else begin
      if (!src) g <= '{run: run_req, en: en_req};
      clk_o <= src & gate_passes(g);
    end
  end

  // R4: output falls only after a low source, rises only after a high one
  p_fall_after_low_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_o) |-> !$past(src));
  p_rise_after_high_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_o) |-> $past(src));
  // R10: gate state frozen while the source is high
  p_gate_frozen_high_r10: assert property (@(posedge clk) disable iff (rst)
    src |=> $stable(g));
endmodule

// File: rtl/ckstop_pair.sv
module ckstop_pair
  import ckstop_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic run_req,
  input  logic en_req,
  output logic t_o,
  output logic c_o
);
  gate_t g;

  always_ff @(posedge clk) begin
    if (rst) begin
      g   <= GATE_OPEN;
      t_o <= 1'b0;
      c_o <= 1'b1;
    end else begin
      if (!src) g <= '{run: run_req, en: en_req};
      t_o <= src & gate_passes(g);
      c_o <= g.en ? ~(src & g.run) : 1'b0;
    end
  end

  // R11: legs never high together, and complementary while enabled
  p_never_both_high_r11: assert property (@(posedge clk) disable iff (rst)
    !(t_o && c_o));
  p_comp_when_enabled_r11: assert property (@(posedge clk) disable iff (rst)
    g.en |=> (c_o != t_o));
  // R4: true leg falls only after a low source
  p_pair_fall_after_low_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(t_o) |-> !$past(src));
  // R10: gate frozen while the source is high
  p_pair_gate_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    src |=> $stable(g));
endmodule

// File: rtl/ckstop_ctrl.sv
module ckstop_ctrl #(
  parameter int               N_PCI         = 6,
  parameter int               N_FREE        = 2,
  parameter int               N_CPU         = 2,
  parameter int               SYNC_STAGES   = 2,
  parameter int               PCI_CAPTURE   = 1,
  parameter int               CPU_CAPTURE   = 2,
  parameter logic [N_CPU-1:0] CPU_STOP_MASK = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pci_src,
  input  logic              cpu_src,
  input  logic              pci_stop_n,
  input  logic              cpu_stop_n,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_FREE-1:0] free_en,
  input  logic [N_CPU-1:0]  cpu_en,
  output logic [N_PCI-1:0]  pci_clk_o,
  output logic [N_FREE-1:0] free_clk_o,
  output logic [N_CPU-1:0]  cpu_t_o,
  output logic [N_CPU-1:0]  cpu_c_o
);
  logic pci_stop_s, cpu_stop_s;
  logic pci_run, cpu_run;

  ckstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pci_sync (
    .clk(clk), .rst(rst), .d(pci_stop_n), .q(pci_stop_s));
  ckstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cpu_sync (
    .clk(clk), .rst(rst), .d(cpu_stop_n), .q(cpu_stop_s));

  ckstop_edge_cap #(.DEPTH(PCI_CAPTURE)) u_pci_cap (
    .clk(clk), .rst(rst), .src(pci_src), .din(pci_stop_s), .q(pci_run));
  ckstop_edge_cap #(.DEPTH(CPU_CAPTURE)) u_cpu_cap (
    .clk(clk), .rst(rst), .src(cpu_src), .din(cpu_stop_s), .q(cpu_run));

  for (genvar i = 0; i < N_PCI; i++) begin : g_pci
    ckstop_gate u_gate (
      .clk(clk), .rst(rst), .src(pci_src), .run_req(pci_run),
      .en_req(pci_en[i]), .clk_o(pci_clk_o[i]));
  end

  for (genvar i = 0; i < N_FREE; i++) begin : g_free
    ckstop_gate u_gate (
      .clk(clk), .rst(rst), .src(pci_src), .run_req(1'b1),
      .en_req(free_en[i]), .clk_o(free_clk_o[i]));
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    if (CPU_STOP_MASK[i]) begin : g_stoppable
      ckstop_pair u_pair (
        .clk(clk), .rst(rst), .src(cpu_src), .run_req(cpu_run),
        .en_req(cpu_en[i]), .t_o(cpu_t_o[i]), .c_o(cpu_c_o[i]));
    end else begin : g_fixed
      ckstop_pair u_pair (
        .clk(clk), .rst(rst), .src(cpu_src), .run_req(1'b1),
        .en_req(cpu_en[i]), .t_o(cpu_t_o[i]), .c_o(cpu_c_o[i]));
    end
  end

  // R3: once the captured PCI request is stop and the source is low, ordinary outputs go low
  p_pci_low_when_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!pci_run && !pci_src && !$past(pci_run)) |=> (pci_clk_o == '0));
endmodule

// File: tb/ckstop_ctrl_test.sv
module ckstop_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PCI_HALF = 4;
  localparam int CPU_HALF = 2;
  localparam int NMON = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pci_src = 1'b0, cpu_src = 1'b0;
  logic pci_stop_n = 1'b1, cpu_stop_n = 1'b1;
  logic [5:0] pci_en = '1;
  logic [1:0] free_en = '1;
  logic [1:0] cpu_en = '1;
  logic [5:0] pci_clk_o;
  logic [1:0] free_clk_o, cpu_t_o, cpu_c_o;

  int n_chk = 0, n_fail = 0;
  int phase = 0;
  int rises [NMON];
  int hl [NMON];
  logic [NMON-1:0] pv = '0;
  logic prev_pci = 1'b0;
  bit chk_free = 0, chk_follow = 0, chk_pair = 0, done = 0;

  ckstop_ctrl uut (
    .clk(clk), .rst(rst), .pci_src(pci_src), .cpu_src(cpu_src),
    .pci_stop_n(pci_stop_n), .cpu_stop_n(cpu_stop_n),
    .pci_en(pci_en), .free_en(free_en), .cpu_en(cpu_en),
    .pci_clk_o(pci_clk_o), .free_clk_o(free_clk_o),
    .cpu_t_o(cpu_t_o), .cpu_c_o(cpu_c_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // source generator: PCI period 8, CPU period 4, both start with a full high phase
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst) begin
        phase = 0; pci_src = 1'b0; cpu_src = 1'b0;
      end else begin
        pci_src = (phase % (2*PCI_HALF)) < PCI_HALF;
        cpu_src = (phase % (2*CPU_HALF)) < CPU_HALF;
        phase++;
      end
    end
  end

  // monitor sampling at the falling edge
  initial begin
    for (int i = 0; i < NMON; i++) begin rises[i] = 0; hl[i] = 0; end
    forever begin
      @(negedge clk);
      if (!rst) begin
        logic [NMON-1:0] v;
        v = {cpu_t_o, free_clk_o, pci_clk_o};
        for (int i = 0; i < NMON; i++) begin
          int half;
          half = (i < 8) ? PCI_HALF : CPU_HALF;
          if (v[i]) begin
            if (!pv[i]) rises[i]++;
            hl[i]++;
          end else if (pv[i]) begin
            chk(hl[i] == half, "R4 pulse width", hl[i], half);
            hl[i] = 0;
          end
        end
        pv = v;
        if (chk_free)
          for (int i = 0; i < 2; i++) chk(free_clk_o[i] == prev_pci, "R2 free output", free_clk_o[i], prev_pci);
        if (chk_follow)
          chk(pci_clk_o == {6{prev_pci}}, "R2 ordinary output", pci_clk_o, {6{prev_pci}});
        if (chk_pair)
          chk(cpu_c_o == ~cpu_t_o, "R11 complement", cpu_c_o, ~cpu_t_o);
        prev_pci = pci_src;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic wait_phase(input int modv, input int ph);
    do begin @(posedge clk); #2; end while ((phase % modv) != ph);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pci_clk_o == 0, "R1 reset ordinary", pci_clk_o, 0);
    chk(free_clk_o == 0, "R1 reset free", free_clk_o, 0);
    chk(cpu_t_o == 0, "R1 reset true", cpu_t_o, 0);
    chk(cpu_c_o == 2'b11, "R1 reset complement", cpu_c_o, 3);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk(cpu_c_o == 2'b11 && pci_clk_o == 0, "R1 first cycle", cpu_c_o, 3);
    chk_free = 1; chk_pair = 1;
    @(negedge clk); chk_follow = 1;
    repeat (64) @(posedge clk);
    chk_follow = 0;

    // PCI stop at every phase offset
    for (int ph = 0; ph < 8; ph++) begin
      int base, d, lat;
      wait_phase(8, ph);
      pci_stop_n = 1'b0;
      @(negedge clk);
      base = rises[0];
      repeat (40) @(negedge clk);
      d = rises[0] - base;
      chk(d >= 1 && d <= 2, "R5 pulses after stop", d, 2);
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        chk(pci_clk_o == 0, "R3 stopped low", pci_clk_o, 0);
      end
      wait_phase(8, (ph + 3) % 8);
      pci_stop_n = 1'b1;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!pci_clk_o[0] && lat < 40);
      chk(lat >= 10 && lat <= 19, "R9 restart latency", lat, 14);
      repeat (16) @(posedge clk);
    end

    // CPU stop at every phase offset
    for (int ph = 0; ph < 8; ph++) begin
      int b0, b1, d0, d1;
      wait_phase(4, ph % 4);
      cpu_stop_n = 1'b0;
      @(negedge clk);
      b0 = rises[8]; b1 = rises[9];
      repeat (30) @(negedge clk);
      d0 = rises[8] - b0; d1 = rises[9] - b1;
      chk(d0 >= 2 && d0 <= 3, "R6 pulses after CPU stop", d0, 3);
      chk(d1 >= 6, "R8 unmasked pair keeps running", d1, 7);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        chk(cpu_t_o[0] == 1'b0 && cpu_c_o[0] == 1'b1, "R7 park state",
            {cpu_t_o[0], cpu_c_o[0]}, 1);
      end
      wait_phase(4, (ph + 1) % 4);
      cpu_stop_n = 1'b1;
      repeat (24) @(negedge clk);
      chk(rises[8] - b0 > d0, "R9 CPU restart", rises[8] - b0, d0 + 1);
    end

    // enable toggles at every phase offset
    chk_pair = 0;
    for (int ph = 0; ph < 8; ph++) begin
      int b;
      wait_phase(8, ph);
      pci_en[0] = 1'b0; cpu_en[0] = 1'b0;
      repeat (20) @(negedge clk);
      pci_stop_n = 1'b0; cpu_stop_n = 1'b0;
      repeat (30) @(negedge clk);
      pci_stop_n = 1'b1; cpu_stop_n = 1'b1;
      repeat (30) @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        chk(pci_clk_o[0] == 1'b0, "R10 disabled stays low", pci_clk_o[0], 0);
        chk(cpu_t_o[0] == 1'b0 && cpu_c_o[0] == 1'b0, "R10 disabled pair low",
            {cpu_t_o[0], cpu_c_o[0]}, 0);
      end
      b = rises[1];
      chk(b > 0, "R10 neighbour unaffected", b, 1);
      wait_phase(8, (ph + 5) % 8);
      b = rises[0];
      pci_en[0] = 1'b1; cpu_en[0] = 1'b1;
      repeat (24) @(negedge clk);
      chk(rises[0] - b >= 1, "R10 re-enable", rises[0] - b, 2);
    end
    chk_pair = 1;
    repeat (16) @(negedge clk);
    finish_run();
  end
endmodule